// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block sits beside a small 8-bit processor core and turns the raw oscillator input into the clock enables the rest of the chip runs on. A toggle stage divides the oscillator by two into a phase enable. A phase counter groups six phase enables into a twelve-clock machine cycle and marks its first phase. The CPU enable and the peripheral enable are both gated versions of the phase enable.

An asynchronous reset pin is synchronised and then filtered. The core reset asserts only after the pin has been seen high for 24 consecutive oscillator clocks while the oscillator runs. Software writes a two-bit power-control register to request one of two low-power modes. Idle stops only the CPU enable, and a wake request from the interrupt controller ends it. Power-down drops the oscillator-run output, and only a qualified reset ends it. When idle ends, the CPU enable comes back at the start of a machine cycle.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `core_rst` asserts only after the synchronised `rst_pin` has been high for 24 consecutive clocks with the oscillator running. A 24-clock pin pulse in run mode resets. A 23-clock pulse does not. A single low sample restarts the count. In power-down the count starts only once the oscillator has restarted, so a pulse there needs 25 clocks.
- R2: While the reset is held, `pcon_q` is 00, `osc_run` is 1, and `phase_en`, `cpu_en` and `periph_en` are 0. `core_rst` falls within 4 clocks of the pin going low.
- R3: While the oscillator runs outside reset, `phase_en` is high on every other clock. `mcyc_first` pulses once every 12 clocks.
- R4: In run mode, a write with `pcon_wdata` = 01 (bit 0 = idle, bit 1 = power-down) enters idle. From the next clock `cpu_en` stays 0, while `periph_en` keeps pulsing on every `phase_en` and `osc_run` stays 1. `pcon_q` reads 01.
- R5: `wake_req` in idle ends idle and clears bit 0 of `pcon_q`. `wake_req` in run mode has no effect.
- R6: In run mode, a write with bit 1 set enters power-down. From the second clock after the write, `osc_run`, `phase_en`, `cpu_en` and `periph_en` are all 0.
- R7: `wake_req` does not end power-down, and neither does a reset pulse shorter than the qualification. `osc_run` returns within 3 clocks of the pin going high in power-down.
- R8: A qualified reset, from any mode, returns the block to run mode with both `pcon_q` bits cleared.
- R9: After a wake from idle, the first `cpu_en` pulse coincides with `mcyc_first` and arrives within 20 clocks.
- R10: A single write with both bits set enters power-down rather than idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Asynchronous reset pin, active high |
| pcon_we | input | 1 | Power-control register write strobe |
| pcon_wdata | input | 2 | Write data: bit 0 idle request, bit 1 power-down request |
| wake_req | input | 1 | Enabled-interrupt wake request |
| phase_en | output | 1 | Divide-by-two internal clock enable |
| cpu_en | output | 1 | CPU clock enable |
| periph_en | output | 1 | Peripheral clock enable |
| mcyc_first | output | 1 | First phase of a machine cycle |
| osc_run | output | 1 | Oscillator run request |
| core_rst | output | 1 | Synchronous core reset, active high |
| pcon_q | output | 2 | Power-control register contents |

## Verification
The reset filter is driven with pulses of 23 and 24 clocks and with a pulse broken by a single low clock. These separate an exact 24-clock threshold from an off-by-one and from a counter that fails to restart. Random pulse lengths well clear of the threshold are then applied from run, idle and power-down, along with random mode writes and wake requests. Each mode is identified by counting the `cpu_en`, `periph_en` and `osc_run` pulses over 24 clocks: run, idle and power-down each give a distinct triple. The wake path is checked on where the first `cpu_en` pulse falls, which shows whether the CPU resumes mid machine cycle or on a boundary.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    M_RUN  = 2'd0,
    M_IDLE = 2'd1,
    M_EXIT = 2'd2,
    M_PD   = 2'd3
  } mode_t;

  localparam int PCON_W   = 2;
  localparam int PCON_IDL = 0;
  localparam int PCON_PD  = 1;
endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 24
) (
  input  logic clk,
  input  logic rst_pin,
  input  logic osc_run,
  output logic pin_sync,
  output logic core_rst
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] QUAL_MAX = CW'(QUAL_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   rst_q;

  assign pin_sync = sync_q[SYNC_STAGES-1];
  assign core_rst = rst_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!pin_sync)
      cnt_d = '0;
    else if (osc_run && (cnt_q != QUAL_MAX))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[SYNC_STAGES-2:0], rst_pin};
    cnt_q  <= cnt_d;
    rst_q  <= (cnt_d == QUAL_MAX);
  end

  always_comb begin
    AST_CNT_BOUND: assert (cnt_q <= QUAL_MAX); // R1
  end

  AST_RST_HOLDS: assert property (@(posedge clk) disable iff (!pin_sync)
    core_rst |=> core_rst); // R1
endmodule

// File: rtl/pmc_clk_div.sv
module pmc_clk_div #(
  parameter int PHASES = 6
) (
  input  logic clk,
  input  logic core_rst,
  input  logic osc_run,
  output logic phase_en,
  output logic mc_first,
  output logic mc_last
);
  localparam int PW = $clog2(PHASES);
  localparam logic [PW-1:0] LAST_IDX = PW'(PHASES - 1);

  logic          pe_q;
  logic [PW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (core_rst) begin
      pe_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      pe_q <= osc_run & ~pe_q;
      if (pe_q)
        idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  assign phase_en = pe_q;
  assign mc_first = pe_q && (idx_q == '0);
  assign mc_last  = pe_q && (idx_q == LAST_IDX);

  AST_PHASE_ALT: assert property (@(posedge clk) disable iff (core_rst)
    phase_en |=> !phase_en); // R3
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (core_rst)
    idx_q <= LAST_IDX); // R3
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pwr_pkg::*;
(
  input  logic              clk,
  input  logic              core_rst,
  input  logic              pin_sync,
  input  logic              pcon_we,
  input  logic [PCON_W-1:0] pcon_wdata,
  input  logic              wake_req,
  input  logic              mc_last,
  input  logic              phase_en,
  output mode_t             mode,
  output logic              osc_run,
  output logic [PCON_W-1:0] pcon_q,
  output logic              cpu_en,
  output logic              periph_en
);
  mode_t             mode_q, mode_d;
  logic [PCON_W-1:0] pcon_r, pcon_d;
  logic              osc_stop_q;

  always_comb begin
    mode_d = mode_q;
    pcon_d = pcon_r;
    case (mode_q)
      M_RUN: begin
        if (pcon_we) begin
          pcon_d = pcon_wdata;
          if (pcon_wdata[PCON_PD])
            mode_d = M_PD;
          else if (pcon_wdata[PCON_IDL])
            mode_d = M_IDLE;
        end
      end
      M_IDLE: begin
        if (wake_req) begin
          mode_d           = M_EXIT;
          pcon_d[PCON_IDL] = 1'b0;
        end
      end
      M_EXIT: begin
        if (mc_last)
          mode_d = M_RUN;
      end
      default: begin
        mode_d = M_PD;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      mode_q     <= M_RUN;
      pcon_r     <= '0;
      osc_stop_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      pcon_r     <= pcon_d;
      osc_stop_q <= (mode_d == M_PD) && !pin_sync;
    end
  end

  assign mode      = mode_q;
  assign pcon_q    = pcon_r;
  assign osc_run   = ~osc_stop_q;
  assign cpu_en    = phase_en && (mode_q == M_RUN);
  assign periph_en = phase_en && (mode_q != M_PD);

  AST_PD_STICKY: assert property (@(posedge clk) disable iff (core_rst)
    (mode_q == M_PD) |=> (mode_q == M_PD)); // R7
  AST_PD_OSC_OFF: assert property (@(posedge clk) disable iff (core_rst)
    ((mode_q == M_PD) && !$past(pin_sync)) |-> !osc_run); // R6
  AST_IDLE_OSC_ON: assert property (@(posedge clk) disable iff (core_rst)
    (mode_q == M_IDLE) |-> osc_run); // R4
  AST_PD_WINS: assert property (@(posedge clk) disable iff (core_rst)
    ((mode_q == M_RUN) && pcon_we && pcon_wdata[PCON_PD]) |=> (mode_q == M_PD)); // R10
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (core_rst)
    $fell(core_rst) |-> ((pcon_q == '0) && (mode_q == M_RUN))); // R8
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int QUAL_CYCLES     = 24,
  parameter int PHASES_PER_MCYC = 6
) (
  input  logic              clk,
  input  logic              rst_pin,
  input  logic              pcon_we,
  input  logic [PCON_W-1:0] pcon_wdata,
  input  logic              wake_req,
  output logic              phase_en,
  output logic              cpu_en,
  output logic              periph_en,
  output logic              mcyc_first,
  output logic              osc_run,
  output logic              core_rst,
  output logic [PCON_W-1:0] pcon_q
);
  logic  pin_sync;
  logic  mc_last;
  mode_t mode;

  pmc_rst_qual #(
    .SYNC_STAGES(SYNC_STAGES),
    .QUAL_CYCLES(QUAL_CYCLES)
  ) u_qual (
    .clk      (clk),
    .rst_pin  (rst_pin),
    .osc_run  (osc_run),
    .pin_sync (pin_sync),
    .core_rst (core_rst)
  );

  pmc_clk_div #(
    .PHASES(PHASES_PER_MCYC)
  ) u_div (
    .clk      (clk),
    .core_rst (core_rst),
    .osc_run  (osc_run),
    .phase_en (phase_en),
    .mc_first (mcyc_first),
    .mc_last  (mc_last)
  );

  pmc_mode_fsm u_fsm (
    .clk        (clk),
    .core_rst   (core_rst),
    .pin_sync   (pin_sync),
    .pcon_we    (pcon_we),
    .pcon_wdata (pcon_wdata),
    .wake_req   (wake_req),
    .mc_last    (mc_last),
    .phase_en   (phase_en),
    .mode       (mode),
    .osc_run    (osc_run),
    .pcon_q     (pcon_q),
    .cpu_en     (cpu_en),
    .periph_en  (periph_en)
  );

  AST_RESUME_ALIGNED: assert property (@(posedge clk) disable iff (core_rst)
    (($past(mode) == M_EXIT) && (mode == M_RUN)) |=> mcyc_first); // R9
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_pin = 1'b0;
  logic       pcon_we = 1'b0;
  logic [1:0] pcon_wdata = 2'b00;
  logic       wake_req = 1'b0;
  logic       phase_en, cpu_en, periph_en, mcyc_first, osc_run, core_rst;
  logic [1:0] pcon_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam int MD_RUN = 0, MD_IDLE = 1, MD_PD = 2;

  always #5 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk(clk), .rst_pin(rst_pin), .pcon_we(pcon_we), .pcon_wdata(pcon_wdata),
    .wake_req(wake_req), .phase_en(phase_en), .cpu_en(cpu_en),
    .periph_en(periph_en), .mcyc_first(mcyc_first), .osc_run(osc_run),
    .core_rst(core_rst), .pcon_q(pcon_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected pulse counts over a 24-clock window: which 0=cpu 1=periph 2=osc
  function automatic int exp_count(input int md, input int which);
    case (md)
      MD_RUN:  return (which == 2) ? 24 : 12;
      MD_IDLE: return (which == 0) ? 0 : ((which == 1) ? 12 : 24);
      default: return 0;
    endcase
  endfunction

  function automatic bit rst_qualifies(input int len, input int md);
    return len >= ((md == MD_PD) ? 25 : 24);
  endfunction

  task automatic observe(input int md, input string req);
    int c_cpu = 0, c_per = 0, c_osc = 0;
    for (int i = 0; i < 24; i++) begin
      cyc(1);
      c_cpu += int'(cpu_en);
      c_per += int'(periph_en);
      c_osc += int'(osc_run);
    end
    chk(c_cpu == exp_count(md, 0), {req, " cpu_en pulses"}, c_cpu, exp_count(md, 0));
    chk(c_per == exp_count(md, 1), {req, " periph_en pulses"}, c_per, exp_count(md, 1));
    chk(c_osc == exp_count(md, 2), {req, " osc_run clocks"}, c_osc, exp_count(md, 2));
  endtask

  task automatic rst_pulse(input int len, output bit saw);
    saw = 1'b0;
    @(negedge clk) rst_pin = 1'b1;
    for (int i = 0; i < len; i++) begin
      cyc(1);
      saw |= core_rst;
    end
    rst_pin = 1'b0;
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      saw |= core_rst;
    end
  endtask

  task automatic wr(input logic [1:0] d);
    @(negedge clk);
    pcon_we = 1'b1;
    pcon_wdata = d;
    @(negedge clk);
    pcon_we = 1'b0;
    pcon_wdata = 2'b00;
  endtask

  task automatic wake();
    @(negedge clk) wake_req = 1'b1;
    @(negedge clk) wake_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit saw;
    int md;
    logic [1:0] exp_pcon;
    int gap;
    int len;
    int op;
    bit found;
    void'($urandom(32'h5eed_1234));

    // R2: hold reset, check reset state
    @(negedge clk) rst_pin = 1'b1;
    cyc(30);
    chk(core_rst == 1'b1, "R2 core_rst held", core_rst, 1);
    chk(phase_en == 0 && cpu_en == 0 && periph_en == 0, "R2 enables quiet",
        {phase_en, cpu_en, periph_en}, 0);
    chk(osc_run == 1'b1, "R2 osc_run in reset", osc_run, 1);
    chk(pcon_q == 2'b00, "R2 pcon after reset", pcon_q, 0);
    rst_pin = 1'b0;
    cyc(4);
    chk(core_rst == 1'b0, "R2 core_rst release", core_rst, 0);

    // R3: divide-by-two and machine-cycle length
    observe(MD_RUN, "R3 run");
    found = 1'b0;
    for (int i = 0; i < 20 && !found; i++) begin
      cyc(1);
      found = mcyc_first;
    end
    gap = 0;
    for (int i = 0; i < 30; i++) begin
      cyc(1);
      gap++;
      if (mcyc_first) break;
    end
    chk(found && gap == 12, "R3 machine cycle period", gap, 12);

    // R1: threshold and restart
    rst_pulse(23, saw);
    chk(!saw, "R1 23-clock pulse", saw, 0);
    rst_pulse(24, saw);
    chk(saw, "R1 24-clock pulse", saw, 1);
    @(negedge clk) rst_pin = 1'b1;
    cyc(20);
    rst_pin = 1'b0;
    cyc(1);
    rst_pin = 1'b1;
    saw = 1'b0;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      saw |= core_rst;
    end
    rst_pin = 1'b0;
    cyc(5);
    chk(!saw, "R1 count restarts on low sample", saw, 0);

    // R5: wake in run ignored
    wake();
    chk(pcon_q == 2'b00, "R5 wake in run pcon", pcon_q, 0);
    observe(MD_RUN, "R5 wake in run");

    // R4: idle
    wr(2'b01);
    cyc(1);
    chk(pcon_q == 2'b01, "R4 pcon idle", pcon_q, 1);
    observe(MD_IDLE, "R4 idle");

    // R9 / R5: wake resumes on boundary
    wake();
    found = 1'b0;
    for (int i = 0; i < 20 && !found; i++) begin
      cyc(1);
      if (cpu_en) begin
        found = 1'b1;
        chk(mcyc_first == 1'b1, "R9 resume aligned", mcyc_first, 1);
      end
    end
    chk(found, "R9 cpu_en returns", found, 1);
    chk(pcon_q == 2'b00, "R5 idle bit cleared", pcon_q, 0);
    observe(MD_RUN, "R5 after wake");

    // R6 / R7: power-down
    wr(2'b10);
    cyc(1);
    chk(pcon_q == 2'b10, "R6 pcon pd", pcon_q, 2);
    observe(MD_PD, "R6 power-down");
    wake();
    observe(MD_PD, "R7 wake ignored");
    rst_pulse(10, saw);
    chk(!saw, "R7 short pulse in pd", saw, 0);
    cyc(3);
    observe(MD_PD, "R7 still pd");
    @(negedge clk) rst_pin = 1'b1;
    cyc(3);
    chk(osc_run == 1'b1, "R7 osc restarts", osc_run, 1);
    cyc(37);
    rst_pin = 1'b0;
    cyc(5);
    chk(pcon_q == 2'b00, "R8 pd exit clears", pcon_q, 0);
    observe(MD_RUN, "R8 run after pd");

    // R10: both bits
    wr(2'b11);
    cyc(1);
    chk(pcon_q == 2'b11, "R10 pcon both", pcon_q, 3);
    observe(MD_PD, "R10 pd wins");
    rst_pulse(40, saw);
    chk(saw && pcon_q == 2'b00, "R8 clear after both", pcon_q, 0);

    // R8: reset from idle
    wr(2'b01);
    cyc(2);
    rst_pulse(30, saw);
    chk(saw && pcon_q == 2'b00, "R8 idle reset clears", pcon_q, 0);
    observe(MD_RUN, "R8 run after idle reset");

    // random mix
    md = MD_RUN;
    exp_pcon = 2'b00;
    for (int it = 0; it < 40; it++) begin
      op = int'($urandom % 5);
      if (op <= 2 && md != MD_RUN) op = 3;
      case (op)
        0: begin wr(2'b01); md = MD_IDLE; exp_pcon = 2'b01; cyc(1); end
        1: begin wr(2'b10); md = MD_PD; exp_pcon = 2'b10; cyc(1); end
        2: begin wr(2'b11); md = MD_PD; exp_pcon = 2'b11; cyc(1); end
        3: begin
          wake();
          if (md == MD_IDLE) begin md = MD_RUN; exp_pcon = 2'b00; end
          cyc(16);
        end
        default: begin
          len = ($urandom % 2 == 0) ? int'(1 + $urandom % 20) : int'(28 + $urandom % 13);
          rst_pulse(len, saw);
          chk(saw == rst_qualifies(len, md), "R1 random pulse", saw, rst_qualifies(len, md));
          if (rst_qualifies(len, md)) begin md = MD_RUN; exp_pcon = 2'b00; end
          cyc(3);
        end
      endcase
      chk(pcon_q == exp_pcon, "R8 random pcon", pcon_q, exp_pcon);
      observe(md, "R5 random mode");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule